// File: doc/BRIEF.md
# Paged Indirect Register Access Bridge

This block is the target side of a management register port. It answers at one fixed management address and exposes a handful of 16-bit registers there. A host uses them to reach a larger internal register space that is split into pages. The host picks a page and an offset and stages up to four 16-bit data words. It then issues a read or a write command. The internal registers are 8 to 64 bits wide.

Once a command is accepted, the bridge holds it pending for a fixed, parameterised number of clock cycles. During that time the host can see the request bits set by polling the command register. When the access finishes, the bridge runs it against the internal register file and clears the request bits. Serial framing is not part of this block. The host side is a parallel port with one register read or write per cycle, and read data comes back in the same cycle.

Top module: `pgreg_bridge`

## Requirements
- R1: Only management address 30 is decoded; it is fixed. A write to any other address, or to an undecoded register number at address 30, has no effect. A read of either returns 0, and `mgmt_rdata_o` is 0 whenever no read is presented.
- R2: Register 0x10 holds the page selection and reads back the full 16 bits last written. Bits 15:8 are the page number and bit 0 is the access enable.
- R3: Register 0x11 reads as {offset[15:8], 6'b0, rd[1], wr[0]}. Writing it with bit 0 or bit 1 set while idle starts an access that targets the written offset. The request bits then read back as written for exactly `ACC_LAT` cycles and return to 0 on the next cycle.
- R4: A write commits the value the data words hold in the cycle the command is issued. Later changes to the data words or to the page register while the access is pending do not alter the committed value.
- R5: Registers 0x18 to 0x1B are data words 0 to 3, with word 0 the least significant. After a read they hold the target value zero-extended to 64 bits, so an 8-bit register appears in the low byte of word 0. A write stores only the target's width, taken from the low bits.
- R6: A command issued while the page enable bit is 0 leaves the internal registers and the data words untouched. Its request bits still clear after `ACC_LAT` cycles.
- R7: A command with both request bits set is performed as a read.
- R8: A read of an unmapped page/offset returns zero in all data words. A write there is discarded. Either one completes with the normal timing.
- R9: While an access is pending, host writes to register 0x11 are ignored. This includes the completion cycle, and covers both the offset and the request bits.
- R10: If a read completes in the same cycle that the host writes a data word, the value from the completed read wins.
- R11: Internal map: 8-bit port controls sit at page 0x00, offsets 0 to NPORT-1. The 8-bit switch mode sits at page 0x00, offset 0x0B. 16-bit port masks sit at page 0x31, offset 2*port, and reset to 0x01FF. A 32-bit word sits at page 0x04, offset 0x00, and a 64-bit word at page 0x04, offset 0x08.
- R12: After reset, the page, command and data registers read 0. The port controls and the mode byte are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mgmt_we_i | input | 1 | Host register write strobe |
| mgmt_re_i | input | 1 | Host register read strobe |
| mgmt_phy_i | input | 5 | Management address of the access |
| mgmt_reg_i | input | 5 | Register number within the address |
| mgmt_wdata_i | input | 16 | Host write data |
| mgmt_rdata_o | output | 16 | Host read data, valid in the strobe cycle |

## Verification
Two things can land on the same clock edge: a pending read retiring into the data words, and a host write to one of those words. A host write to the command register can also coincide with the completion of an access. The bench provokes both by counting the latency and placing the host write exactly in the final pending cycle. The reference model then judges the result: the retiring read must own the data word, and the stray command must leave neither offset nor request bits behind. A host read is compared against the model on every cycle, so any other ordering shows up in the next poll.

// File: rtl/pgreg_pkg.sv
package pgreg_pkg;
  localparam logic [4:0] PHY_ADDR = 5'd30;
  localparam logic [4:0] REG_PAGE = 5'h10;
  localparam logic [4:0] REG_CMD  = 5'h11;
  localparam logic [4:0] REG_D0   = 5'h18;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/pgreg_host_regs.sv
module pgreg_host_regs
  import pgreg_pkg::*;
#(
  parameter int DW    = 16,
  parameter int NWORD = 4,
  localparam int XW   = DW * NWORD
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [4:0]    reg_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          busy_i,
  input  logic          done_i,
  input  logic          load_i,
  input  logic [XW-1:0] load_data_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] page_o,
  output logic [7:0]    off_o,
  output logic [1:0]    pend_o,
  output logic [XW-1:0] data_o,
  output logic          issue_o,
  output op_e           issue_op_o
);
  logic [DW-1:0] page_q;
  logic [7:0]    off_q;
  logic [1:0]    pend_q;
  logic [DW-1:0] word_q [NWORD];
  logic          cmd_wr;

  assign cmd_wr  = wr_en_i && (reg_i == REG_CMD) && !busy_i;
  assign issue_o = cmd_wr && (wdata_i[1:0] != 2'b00);

  always_comb begin
    if (!page_q[0])      issue_op_o = OP_NONE;
    else if (wdata_i[1]) issue_op_o = OP_RD;
    else                 issue_op_o = OP_WR;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      off_q  <= '0;
      pend_q <= '0;
    end else begin
      if (wr_en_i && reg_i == REG_PAGE) page_q <= wdata_i;
      if (cmd_wr) begin
        off_q  <= wdata_i[15:8];
        pend_q <= wdata_i[1:0];
      end else if (done_i) begin
        pend_q <= '0;
      end
    end
  end

  for (genvar w = 0; w < NWORD; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        word_q[w] <= '0;
      else if (load_i)
        word_q[w] <= load_data_i[w*DW +: DW];
      else if (wr_en_i && reg_i == REG_D0 + 5'(w))
        word_q[w] <= wdata_i;
    end
    assign data_o[w*DW +: DW] = word_q[w];
  end

  always_comb begin
    rdata_o = '0;
    if (reg_i == REG_PAGE)     rdata_o = page_q;
    else if (reg_i == REG_CMD) rdata_o = {off_q, 6'b0, pend_q};
    else begin
      for (int w = 0; w < NWORD; w++)
        if (reg_i == REG_D0 + 5'(w)) rdata_o = word_q[w];
    end
  end

  assign page_o = page_q;
  assign off_o  = off_q;
  assign pend_o = pend_q;

  // R9
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && wr_en_i && reg_i == REG_CMD) |=> $stable(off_q));
endmodule

// File: rtl/pgreg_seq.sv
module pgreg_seq
  import pgreg_pkg::*;
#(
  parameter int ACC_LAT = 4,
  parameter int XW      = 64,
  localparam int CW     = (ACC_LAT > 2) ? $clog2(ACC_LAT) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          issue_i,
  input  op_e           op_i,
  input  logic [7:0]    page_i,
  input  logic [7:0]    off_i,
  input  logic [XW-1:0] data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          st_wr_o,
  output logic          load_o,
  output logic [7:0]    st_page_o,
  output logic [7:0]    st_off_o,
  output logic [XW-1:0] st_wdata_o
);
  logic          busy_q;
  logic [CW-1:0] cnt_q;
  op_e           op_q;
  logic [7:0]    page_q, off_q;
  logic [XW-1:0] data_q;

  assign done_o = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_NONE;
      page_q <= '0;
      off_q  <= '0;
      data_q <= '0;
    end else if (issue_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(ACC_LAT - 1);
      op_q   <= op_i;
      page_q <= page_i;
      off_q  <= off_i;
      data_q <= data_i;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o     = busy_q;
  assign st_wr_o    = done_o && (op_q == OP_WR);
  assign load_o     = done_o && (op_q == OP_RD);
  assign st_page_o  = page_q;
  assign st_off_o   = off_q;
  assign st_wdata_o = data_q;

  // R3
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  // R3
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cnt_q <= CW'(ACC_LAT - 1)));
  // R4
  snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> (busy_o && $stable(data_q) && $stable(page_q)));
endmodule

// File: rtl/pgreg_store.sv
module pgreg_store #(
  parameter int          NPORT     = 9,
  parameter logic [7:0]  MODE_OFF  = 8'h0B,
  parameter logic [7:0]  MASK_PAGE = 8'h31,
  parameter logic [7:0]  WIDE_PAGE = 8'h04,
  parameter logic [15:0] MASK_RST  = 16'h01FF,
  localparam int         XW        = 64,
  localparam int         NHIT      = 2 * NPORT + 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [7:0]    page_i,
  input  logic [7:0]    off_i,
  input  logic [XW-1:0] wdata_i,
  output logic [XW-1:0] rdata_o
);
  logic [7:0]  ctrl_q [NPORT];
  logic [15:0] mask_q [NPORT];
  logic [7:0]  mode_q;
  logic [31:0] w32_q;
  logic [63:0] w64_q;
  logic [NPORT-1:0] hit_ctrl, hit_mask;
  logic hit_mode, hit_w32, hit_w64;
  logic [NHIT-1:0] hit_vec;
  logic [XW-1:0] port_rd [NPORT];

  assign hit_mode = (page_i == 8'h00) && (off_i == MODE_OFF);
  assign hit_w32  = (page_i == WIDE_PAGE) && (off_i == 8'h00);
  assign hit_w64  = (page_i == WIDE_PAGE) && (off_i == 8'h08);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign hit_ctrl[p] = (page_i == 8'h00) && (off_i == 8'(p));
    assign hit_mask[p] = (page_i == MASK_PAGE) && (off_i == 8'(2 * p));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctrl_q[p] <= '0;
        mask_q[p] <= MASK_RST;
      end else if (wr_i) begin
        if (hit_ctrl[p]) ctrl_q[p] <= wdata_i[7:0];
        if (hit_mask[p]) mask_q[p] <= wdata_i[15:0];
      end
    end

    assign port_rd[p] = (hit_ctrl[p] ? {56'b0, ctrl_q[p]} : '0) |
                        (hit_mask[p] ? {48'b0, mask_q[p]} : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      w32_q  <= '0;
      w64_q  <= '0;
    end else if (wr_i) begin
      if (hit_mode) mode_q <= wdata_i[7:0];
      if (hit_w32)  w32_q  <= wdata_i[31:0];
      if (hit_w64)  w64_q  <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int p = 0; p < NPORT; p++) rdata_o = rdata_o | port_rd[p];
    if (hit_mode) rdata_o = rdata_o | {56'b0, mode_q};
    if (hit_w32)  rdata_o = rdata_o | {32'b0, w32_q};
    if (hit_w64)  rdata_o = rdata_o | w64_q;
  end

  assign hit_vec = {hit_ctrl, hit_mask, hit_mode, hit_w32, hit_w64};

  // R11
  hit_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
endmodule

// File: rtl/pgreg_bridge.sv
module pgreg_bridge
  import pgreg_pkg::*;
#(
  parameter int ACC_LAT = 4,
  parameter int NPORT   = 9
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        mgmt_we_i,
  input  logic        mgmt_re_i,
  input  logic [4:0]  mgmt_phy_i,
  input  logic [4:0]  mgmt_reg_i,
  input  logic [15:0] mgmt_wdata_i,
  output logic [15:0] mgmt_rdata_o
);
  localparam int DW    = 16;
  localparam int NWORD = 4;
  localparam int XW    = DW * NWORD;

  logic          addr_hit, wr_en;
  logic [DW-1:0] host_rdata, page;
  logic [7:0]    off;
  logic [1:0]    pend;
  logic [XW-1:0] staged, st_rdata, st_wdata;
  logic          issue, busy, done, st_wr, load;
  op_e           issue_op;
  logic [7:0]    st_page, st_off;

  assign addr_hit = (mgmt_phy_i == PHY_ADDR);
  assign wr_en    = mgmt_we_i && addr_hit;

  pgreg_host_regs #(.DW(DW), .NWORD(NWORD)) u_host (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .reg_i(mgmt_reg_i), .wdata_i(mgmt_wdata_i),
    .busy_i(busy), .done_i(done), .load_i(load), .load_data_i(st_rdata),
    .rdata_o(host_rdata), .page_o(page), .off_o(off), .pend_o(pend),
    .data_o(staged), .issue_o(issue), .issue_op_o(issue_op)
  );

  pgreg_seq #(.ACC_LAT(ACC_LAT), .XW(XW)) u_seq (
    .clk_i, .rst_ni,
    .issue_i(issue), .op_i(issue_op), .page_i(page[15:8]),
    .off_i(mgmt_wdata_i[15:8]), .data_i(staged),
    .busy_o(busy), .done_o(done), .st_wr_o(st_wr), .load_o(load),
    .st_page_o(st_page), .st_off_o(st_off), .st_wdata_o(st_wdata)
  );

  pgreg_store #(.NPORT(NPORT)) u_store (
    .clk_i, .rst_ni,
    .wr_i(st_wr), .page_i(st_page), .off_i(st_off),
    .wdata_i(st_wdata), .rdata_o(st_rdata)
  );

  assign mgmt_rdata_o = (mgmt_re_i && addr_hit) ? host_rdata : '0;

  // R3
  pend_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend != 2'b00) == busy));
  // R9
  off_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (off == st_off));
endmodule

// File: tb/pgreg_bridge_tb.sv
module pgreg_bridge_tb;
  localparam int LAT   = 4;
  localparam int NPORT = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0, re = 1'b0;
  logic [4:0] phy = '0, rg = '0;
  logic [15:0] wd = '0;
  logic [15:0] rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pgreg_bridge #(.ACC_LAT(LAT), .NPORT(NPORT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mgmt_we_i(we), .mgmt_re_i(re),
    .mgmt_phy_i(phy), .mgmt_reg_i(rg), .mgmt_wdata_i(wd), .mgmt_rdata_o(rdata)
  );

  // reference model
  logic [15:0] m_page, m_data[4];
  logic [7:0]  m_off;
  logic [1:0]  m_pend;
  bit          m_busy;
  int          m_cnt;
  int          m_op;            // 0 none, 1 read, 2 write
  logic [7:0]  m_spage, m_soff;
  logic [63:0] m_sdata;
  logic [7:0]  s_ctrl[NPORT];
  logic [15:0] s_mask[NPORT];
  logic [7:0]  s_mode;
  logic [31:0] s_w32;
  logic [63:0] s_w64;

  task automatic model_reset();
    m_page = 0; m_off = 0; m_pend = 0; m_busy = 0; m_cnt = 0; m_op = 0;
    for (int i = 0; i < 4; i++) m_data[i] = 0;
    for (int p = 0; p < NPORT; p++) begin s_ctrl[p] = 0; s_mask[p] = 16'h01FF; end
    s_mode = 0; s_w32 = 0; s_w64 = 0;
  endtask

  function automatic logic [63:0] st_rd(input logic [7:0] pg, input logic [7:0] of);
    st_rd = 64'h0;
    if (pg == 8'h00 && of < NPORT) st_rd = {56'h0, s_ctrl[of]};
    else if (pg == 8'h00 && of == 8'h0B) st_rd = {56'h0, s_mode};
    else if (pg == 8'h31 && of[0] == 1'b0 && (of >> 1) < NPORT) st_rd = {48'h0, s_mask[of >> 1]};
    else if (pg == 8'h04 && of == 8'h00) st_rd = {32'h0, s_w32};
    else if (pg == 8'h04 && of == 8'h08) st_rd = s_w64;
  endfunction

  task automatic st_wr(input logic [7:0] pg, input logic [7:0] of, input logic [63:0] d);
    if (pg == 8'h00 && of < NPORT) s_ctrl[of] = d[7:0];
    else if (pg == 8'h00 && of == 8'h0B) s_mode = d[7:0];
    else if (pg == 8'h31 && of[0] == 1'b0 && (of >> 1) < NPORT) s_mask[of >> 1] = d[15:0];
    else if (pg == 8'h04 && of == 8'h00) s_w32 = d[31:0];
    else if (pg == 8'h04 && of == 8'h08) s_w64 = d;
  endtask

  function automatic logic [15:0] host_rd(input logic [4:0] r);
    host_rd = 16'h0;
    case (r)
      5'h10: host_rd = m_page;
      5'h11: host_rd = {m_off, 6'b0, m_pend};
      5'h18: host_rd = m_data[0];
      5'h19: host_rd = m_data[1];
      5'h1A: host_rd = m_data[2];
      5'h1B: host_rd = m_data[3];
      default: host_rd = 16'h0;
    endcase
  endfunction

  // one host cycle: drive, compare at mid-cycle, update model at edge
  task automatic step(input bit w, input bit r, input logic [4:0] a,
                      input logic [4:0] n, input logic [15:0] d, input string tag);
    logic [15:0] exp;
    bit done_now, load_now, hit;
    we = w; re = r; phy = a; rg = n; wd = d;
    #4;
    hit = (a == 5'd30);
    exp = (r && hit) ? host_rd(n) : 16'h0;
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s: reg 0x%0h actual=0x%04h expected=0x%04h", tag, n, rdata, exp);
    end
    @(posedge clk);
    done_now = m_busy && (m_cnt == 0);
    load_now = done_now && (m_op == 1);
    if (done_now) begin
      if (m_op == 1) begin
        logic [63:0] v;
        v = st_rd(m_spage, m_soff);
        for (int i = 0; i < 4; i++) m_data[i] = v[i*16 +: 16];
      end else if (m_op == 2) begin
        st_wr(m_spage, m_soff, m_sdata);
      end
    end
    if (w && hit) begin
      if (n == 5'h10) m_page = d;
      if (n >= 5'h18 && n <= 5'h1B && !load_now) m_data[n - 5'h18] = d;
      if (n == 5'h11 && !m_busy) begin
        m_off = d[15:8];
        m_pend = d[1:0];
        if (d[1:0] != 2'b00) begin
          m_soff = d[15:8];
          m_spage = m_page[15:8];
          if (n == 5'h11) m_spage = m_page[15:8];
          m_sdata = {m_data[3], m_data[2], m_data[1], m_data[0]};
          m_op = !m_page[0] ? 0 : (d[1] ? 1 : 2);
        end
      end
    end
    if (w && hit && n == 5'h11 && !m_busy && d[1:0] != 2'b00) begin
      m_busy = 1; m_cnt = LAT - 1;
    end else if (done_now) begin
      m_busy = 0; m_pend = 0;
    end else if (m_busy) begin
      m_cnt--;
    end
    #1;
  endtask

  task automatic wr(input logic [4:0] n, input logic [15:0] d, input string tag);
    step(1, 0, 5'd30, n, d, tag);
  endtask
  task automatic rd(input logic [4:0] n, input string tag);
    step(0, 1, 5'd30, n, 16'h0, tag);
  endtask
  task automatic poll(input string tag);
    for (int i = 0; i < 3 * LAT && m_busy; i++) rd(5'h11, tag);
    rd(5'h11, tag);
  endtask
  task automatic rd_words(input string tag);
    for (int i = 0; i < 4; i++) rd(5'(5'h18 + i), tag);
  endtask
  task automatic stage(input logic [63:0] v, input string tag);
    for (int i = 0; i < 4; i++) wr(5'(5'h18 + i), v[i*16 +: 16], tag);
  endtask
  task automatic acc_wr(input logic [7:0] pg, input logic [7:0] of,
                        input logic [63:0] v, input string tag);
    wr(5'h10, {pg, 8'h01}, tag);
    stage(v, tag);
    wr(5'h11, {of, 8'h01}, tag);
    poll(tag);
  endtask
  task automatic acc_rd(input logic [7:0] pg, input logic [7:0] of, input string tag);
    wr(5'h10, {pg, 8'h01}, tag);
    stage(64'hDEAD_BEEF_CAFE_F00D, tag);
    wr(5'h11, {of, 8'h02}, tag);
    poll(tag);
    rd_words(tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R12 reset state
    rd(5'h10, "R12"); rd(5'h11, "R12"); rd_words("R12");
    acc_rd(8'h00, 8'h02, "R12"); acc_rd(8'h00, 8'h0B, "R12");
    // R1 other address / unknown register
    step(1, 0, 5'd5, 5'h10, 16'hABCD, "R1");
    step(0, 1, 5'd5, 5'h10, 16'h0, "R1");
    wr(5'h12, 16'h1234, "R1");
    rd(5'h12, "R1"); rd(5'h10, "R1");
    step(0, 0, 5'd30, 5'h10, 16'h0, "R1");
    // R2 page readback
    wr(5'h10, 16'hA55A, "R2"); rd(5'h10, "R2");
    // R3/R11 port control write then read
    acc_wr(8'h00, 8'h03, 64'h0000_0000_0000_00A5, "R3");
    acc_rd(8'h00, 8'h03, "R11");
    acc_wr(8'h00, 8'h08, 64'h0000_0000_0000_003C, "R11");
    acc_rd(8'h00, 8'h08, "R11");
    // R5 truncation, low byte placement
    acc_wr(8'h00, 8'h0B, 64'h1111_2222_3333_44FF, "R5");
    acc_rd(8'h00, 8'h0B, "R5");
    // R11 mask reset and update
    acc_rd(8'h31, 8'h04, "R11");
    acc_wr(8'h31, 8'h10, 64'h0000_0000_0000_FFFF, "R11");
    acc_rd(8'h31, 8'h10, "R11");
    acc_rd(8'h31, 8'h05, "R8");
    // R5 wide registers
    acc_wr(8'h04, 8'h08, 64'h4444_3333_2222_1111, "R5");
    acc_rd(8'h04, 8'h08, "R5");
    acc_wr(8'h04, 8'h00, 64'h9999_8888_7777_6666, "R5");
    acc_rd(8'h04, 8'h00, "R5");
    // R4 staging overwritten while pending
    wr(5'h10, 16'h0001, "R4");
    stage(64'h0000_0000_0000_0077, "R4");
    wr(5'h11, 16'h0101, "R4");
    wr(5'h18, 16'h00EE, "R4");
    wr(5'h10, 16'h0401, "R4");
    poll("R4");
    acc_rd(8'h00, 8'h01, "R4");
    // R6 disabled page
    wr(5'h10, 16'h0000, "R6");
    stage(64'h0000_0000_0000_0055, "R6");
    wr(5'h11, 16'h0301, "R6");
    poll("R6");
    wr(5'h11, 16'h0302, "R6");
    poll("R6");
    rd_words("R6");
    acc_rd(8'h00, 8'h03, "R6");
    // R7 both bits
    wr(5'h10, 16'h0001, "R7");
    stage(64'h0000_0000_0000_0011, "R7");
    wr(5'h11, 16'h0303, "R7");
    poll("R7");
    rd_words("R7");
    acc_rd(8'h00, 8'h03, "R7");
    // R8 unmapped
    acc_wr(8'h07, 8'h00, 64'h1234_5678_9ABC_DEF0, "R8");
    acc_rd(8'h07, 8'h00, "R8");
    acc_rd(8'h00, 8'h20, "R8");
    // R9 command writes during pending, incl. completion cycle
    wr(5'h10, 16'h0001, "R9");
    wr(5'h11, 16'h0202, "R9");
    for (int i = 0; i < LAT - 1; i++) wr(5'h11, 16'h0901, "R9");
    wr(5'h11, 16'h0A01, "R9");
    rd(5'h11, "R9");
    acc_rd(8'h00, 8'h09, "R9");
    // R10 read completion vs data word write
    wr(5'h10, 16'h0001, "R10");
    wr(5'h11, 16'h0302, "R10");
    for (int i = 0; i < LAT - 1; i++) rd(5'h11, "R10");
    wr(5'h18, 16'hBEEF, "R10");
    rd_words("R10");
    wr(5'h19, 16'h4321, "R10");
    rd(5'h19, "R10");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule